// File: doc/BRIEF.md
# Key Vault Register Controller

This block is the register front end of a small key store kept in an always-on domain. It holds eight 32-bit key words and one extra 32-bit word. All of them sit behind a simple 32-bit register port that is accessed one word at a time. Key words are loaded only after an unlock word has been written. The unlock also wipes the store. Once loaded, keys can never be read back. Software proves that it loaded the right key by writing a checksum. The block then walks the stored words one per cycle through a CRC engine and reports done and match flags.

The extra word follows its own rules, which depend on a configuration input. In one setting it is write-only, it is wiped with the keys, and a lock cannot be applied to it. In the other setting it can be read back and a sticky lock freezes it. The same input decides whether the CRC walk starts with an all-zero word. An error-event input feeds one interrupt line through status, mask, mask-clear and mask-set registers.

Key words have no reset, so they keep their contents through `rst_n`. Every control and status register is reset by `rst_n`.

Top module: `keyvault_regctl`

## Requirements
- R1: After reset, these registers read zero: status (0x00), interrupt status (0x38), lock (0x4C) and error-enable (0x34). The interrupt mask (0x3C) reads 1, and `irq` and `slverr_en` are low. Status bits: bit 9 = CRC match, bit 8 = CRC done, bit 4 = wiped, bit 0 = program mode.
- R2: Writing exactly 0x757BDF0D to 0x08 wipes the store and sets status bits 0 and 4. Any other value has no effect. Bit 0 stays set until `rst_n`.
- R3: Reads of key words (0x10 to 0x2C), of the checksum register (0x0C), of 0x04, 0x08, 0x40 and 0x44 return zero. A key write is accepted only while status bit 0 is set.
- R4: Writing 1 to bit 0 of 0x04 wipes the key words and sets status bit 4, and the command bit reads back 0. The extra word (0x30) is cleared by a wipe only when `cfg_zero_pad` is 1.
- R5: Status bit 4 clears when an accepted write puts a nonzero value into a key word. A write of zero leaves it set. A write to the extra word clears it only when `cfg_zero_pad` is 1.
- R6: The extra word accepts a write only while status bit 0 is set and the lock is clear. It reads 0 when `cfg_zero_pad` is 1 and its stored value otherwise.
- R7: Writing 1 to bit 0 of 0x4C sets a lock that only `rst_n` clears. While `cfg_zero_pad` is 1 the lock cannot be set and reads 0.
- R8: A write to 0x0C while in program mode clears status bits 8 and 9 and starts a CRC walk. The CRC is reflected, with polynomial 0x82F63B78, initial value 0xFFFFFFFF and final inversion. Each word is fed least significant byte first, in the order: a zero word when `cfg_zero_pad` is 1, then key words 0 to 7. Bit 8 sets 9 clock edges after the write edge with the zero word, or 8 edges without it. In the same edge, bit 9 is set when the result equals the written value.
- R9: A write to 0x0C outside program mode leaves status bits 8 and 9 unchanged.
- R10: `err_event` sets bit 0 of 0x38, and writing 1 to that bit clears it. Writing 1 to 0x40 clears the mask, and writing 1 to 0x44 sets it. `irq` is high exactly when the status bit is set and the mask is clear.
- R11: `rst_n` leaves the stored key words and the extra word unchanged.
- R12: An access with `bus_word` low changes nothing and reads zero.
- R13: A new write to 0x0C during a CRC walk restarts it. Done and match read 0 until the restarted walk completes.
- R14: Bit 0 of 0x34 is a read/write enable that drives `slverr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| cfg_zero_pad | input | 1 | 1: zero word before keys in CRC, extra word write-only |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = full 32-bit access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| err_event | input | 1 | Error event pulse into interrupt status |
| slverr_en | output | 1 | Error-response enable bit |
| irq | output | 1 | Interrupt request |

## Verification
The CRC check is swept over single-key patterns, one nonzero word per key slot, so that a fault in word order, in indexing or in the zero-word prefix shows up as a missing match. Each walk is sampled on the edge before and on the edge of completion. This separates the 8-word latency from the 9-word latency and catches off-by-one in the walk. A checksum computed without the prefix is offered in prefix mode to show that the prefix really enters the result. Partial-width reads are swept over the whole address space, and wipes and locks are tried in both settings of `cfg_zero_pad`.

// File: rtl/kv_pkg.sv
package kv_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned OFS_STATUS = 'h00;
  localparam int unsigned OFS_CMD    = 'h04;
  localparam int unsigned OFS_UNLOCK = 'h08;
  localparam int unsigned OFS_CHECK  = 'h0C;
  localparam int unsigned KEY_BASE   = 'h10;
  localparam int unsigned OFS_ERREN  = 'h34;
  localparam int unsigned OFS_ISR    = 'h38;
  localparam int unsigned OFS_IMR    = 'h3C;
  localparam int unsigned OFS_UNMASK = 'h40;
  localparam int unsigned OFS_MASK   = 'h44;
  localparam int unsigned OFS_LOCK   = 'h4C;
  localparam logic [31:0] CRC_POLY   = 32'h82F63B78;

  // One 32-bit word through the reflected CRC, bit 0 first.
  function automatic logic [31:0] crc_word(input logic [31:0] crc_in,
                                           input logic [31:0] data);
    logic [31:0] c;
    c = crc_in ^ data;
    for (int b = 0; b < 32; b++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/kv_keystore.sv
module kv_keystore #(
  parameter int unsigned KEY_WORDS = 8,
  localparam int unsigned IW = $clog2(KEY_WORDS)
) (
  input  logic                               clk,
  input  logic                               wipe,
  input  logic                               wipe_ext,
  input  logic                               key_we,
  input  logic [IW-1:0]                      key_sel,
  input  logic                               ext_we,
  input  logic [31:0]                        wdata,
  output logic [KEY_WORDS-1:0][31:0]         keys,
  output logic [31:0]                        ext_word
);
  // Storage cells sit in the retained domain: no reset on purpose.
  for (genvar i = 0; i < KEY_WORDS; i++) begin : g_key
    logic        en;
    logic [31:0] d;
    assign en = wipe | (key_we & (key_sel == IW'(i)));
    assign d  = wipe ? '0 : wdata;
    always_ff @(posedge clk) begin
      if (en) keys[i] <= d;
    end
  end

  logic        ext_en;
  logic [31:0] ext_d;
  assign ext_en = wipe_ext | ext_we;
  assign ext_d  = wipe_ext ? '0 : wdata;
  always_ff @(posedge clk) begin
    if (ext_en) ext_word <= ext_d;
  end
endmodule

// File: rtl/kv_crc_engine.sv
module kv_crc_engine #(
  parameter int unsigned KEY_WORDS = 8,
  localparam int unsigned CW = $clog2(KEY_WORDS + 1),
  localparam int unsigned IW = $clog2(KEY_WORDS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       pad_en,
  input  logic [31:0]                expect_val,
  input  logic [KEY_WORDS-1:0][31:0] keys,
  output logic                       busy,
  output logic                       done,
  output logic                       pass
);
  logic          busy_q, busy_d, done_q, done_d, pass_q, pass_d;
  logic [CW-1:0] idx_q, idx_d;
  logic [31:0]   crc_q, crc_d, exp_q, exp_d, cur, crc_nxt;
  logic [IW-1:0] sel;
  logic          last;

  assign sel     = IW'(idx_q - CW'(1));
  assign cur     = (idx_q == '0) ? '0 : keys[sel];
  assign crc_nxt = kv_pkg::crc_word(crc_q, cur);
  assign last    = (idx_q == CW'(KEY_WORDS));

  always_comb begin
    busy_d = busy_q; done_d = done_q; pass_d = pass_q;
    idx_d  = idx_q;  crc_d  = crc_q;  exp_d  = exp_q;
    if (start) begin
      busy_d = 1'b1;
      done_d = 1'b0;
      pass_d = 1'b0;
      idx_d  = pad_en ? '0 : CW'(1);
      crc_d  = '1;
      exp_d  = expect_val;
    end else if (busy_q) begin
      crc_d = crc_nxt;
      idx_d = idx_q + CW'(1);
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        pass_d = (~crc_nxt == exp_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; pass_q <= 1'b0;
      idx_q  <= '0;   crc_q  <= '0;   exp_q  <= '0;
    end else begin
      busy_q <= busy_d; done_q <= done_d; pass_q <= pass_d;
      idx_q  <= idx_d;  crc_q  <= crc_d;  exp_q  <= exp_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign pass = pass_q;
endmodule

// File: rtl/kv_irq.sv
module kv_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  input  logic unmask,
  input  logic mask,
  output logic isr,
  output logic imr,
  output logic irq
);
  logic isr_q, isr_d, imr_q, imr_d;

  always_comb begin
    isr_d = (isr_q & ~clr) | evt;
    imr_d = (imr_q & ~unmask) | mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= 1'b0;
      imr_q <= 1'b1;
    end else begin
      isr_q <= isr_d;
      imr_q <= imr_d;
    end
  end

  assign isr = isr_q;
  assign imr = imr_q;
  assign irq = isr_q & ~imr_q;
endmodule

// File: rtl/keyvault_regctl.sv
module keyvault_regctl #(
  parameter int unsigned KEY_WORDS = 8,
  parameter int unsigned ADDR_W    = 7,
  parameter logic [31:0] UNLOCK_KEY = 32'h757BDF0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_zero_pad,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              err_event,
  output logic              slverr_en,
  output logic              irq
);
  import kv_pkg::*;
  localparam int unsigned IW      = $clog2(KEY_WORDS);
  localparam int unsigned EXT_OFS = KEY_BASE + 4 * KEY_WORDS;

  logic wr, rd, key_hit, key_we, ext_we, ext_open, wipe, unlock, zero_cmd, crc_start;
  logic pgm_q, pgm_d, lock_q, lock_d, zeroized_q, zeroized_d, erren_q, erren_d;
  logic lock_eff, crc_busy, crc_done, crc_pass, irq_isr, irq_imr;
  logic [IW-1:0] key_sel;
  logic [KEY_WORDS-1:0][31:0] keys;
  logic [31:0] ext_word;
  logic [ADDR_W-1:0] key_off;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign wr        = bus_sel & bus_we & bus_word;
  assign rd        = bus_sel & ~bus_we & bus_word;
  assign key_hit   = (bus_addr >= ADDR_W'(KEY_BASE)) && (bus_addr < ADDR_W'(EXT_OFS))
                     && (bus_addr[1:0] == 2'b00);
  assign key_off   = bus_addr - ADDR_W'(KEY_BASE);
  assign key_sel   = IW'(key_off >> 2);
  assign unlock    = wr & hit(bus_addr, OFS_UNLOCK) & (bus_wdata == UNLOCK_KEY);
  assign zero_cmd  = wr & hit(bus_addr, OFS_CMD) & bus_wdata[0];
  assign wipe      = unlock | zero_cmd;
  assign lock_eff  = lock_q & ~cfg_zero_pad;
  assign ext_open  = pgm_q & ~lock_eff;
  assign key_we    = wr & key_hit & pgm_q;
  assign ext_we    = wr & hit(bus_addr, EXT_OFS) & ext_open;
  assign crc_start = wr & hit(bus_addr, OFS_CHECK) & pgm_q;

  always_comb begin
    pgm_d      = pgm_q | unlock;
    lock_d     = lock_q | (wr & hit(bus_addr, OFS_LOCK) & bus_wdata[0] & ~cfg_zero_pad);
    erren_d    = (wr & hit(bus_addr, OFS_ERREN)) ? bus_wdata[0] : erren_q;
    zeroized_d = zeroized_q;
    if (wipe)
      zeroized_d = 1'b1;
    else if ((key_we | (ext_we & cfg_zero_pad)) && (bus_wdata != '0))
      zeroized_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgm_q      <= 1'b0;
      lock_q     <= 1'b0;
      erren_q    <= 1'b0;
      zeroized_q <= 1'b0;
    end else begin
      pgm_q      <= pgm_d;
      lock_q     <= lock_d;
      erren_q    <= erren_d;
      zeroized_q <= zeroized_d;
    end
  end

  kv_keystore #(.KEY_WORDS(KEY_WORDS)) u_store (
    .clk(clk), .wipe(wipe), .wipe_ext(wipe & cfg_zero_pad),
    .key_we(key_we), .key_sel(key_sel), .ext_we(ext_we),
    .wdata(bus_wdata), .keys(keys), .ext_word(ext_word)
  );

  kv_crc_engine #(.KEY_WORDS(KEY_WORDS)) u_crc (
    .clk(clk), .rst_n(rst_n), .start(crc_start), .pad_en(cfg_zero_pad),
    .expect_val(bus_wdata), .keys(keys),
    .busy(crc_busy), .done(crc_done), .pass(crc_pass)
  );

  kv_irq u_irq (
    .clk(clk), .rst_n(rst_n), .evt(err_event),
    .clr(wr & hit(bus_addr, OFS_ISR) & bus_wdata[0]),
    .unmask(wr & hit(bus_addr, OFS_UNMASK) & bus_wdata[0]),
    .mask(wr & hit(bus_addr, OFS_MASK) & bus_wdata[0]),
    .isr(irq_isr), .imr(irq_imr), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (hit(bus_addr, OFS_STATUS))
        bus_rdata = {22'b0, crc_pass, crc_done, 3'b0, zeroized_q, 3'b0, pgm_q};
      else if (hit(bus_addr, EXT_OFS))
        bus_rdata = cfg_zero_pad ? '0 : ext_word;
      else if (hit(bus_addr, OFS_ERREN))
        bus_rdata = {31'b0, erren_q};
      else if (hit(bus_addr, OFS_ISR))
        bus_rdata = {31'b0, irq_isr};
      else if (hit(bus_addr, OFS_IMR))
        bus_rdata = {31'b0, irq_imr};
      else if (hit(bus_addr, OFS_LOCK))
        bus_rdata = {31'b0, lock_eff};
    end
  end

  assign slverr_en = erren_q;
endmodule

// File: rtl/kv_regctl_checker.sv
module kv_regctl_checker #(
  parameter int unsigned ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_zero_pad,
  input logic              bus_sel,
  input logic              bus_we,
  input logic              bus_word,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic              pgm_q,
  input logic              lock_q,
  input logic              zeroized_q,
  input logic              crc_busy,
  input logic              crc_done
);
  logic wr, rd;
  assign wr = bus_sel & bus_we & bus_word;
  assign rd = bus_sel & ~bus_we & bus_word;

  assert_pgm_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_q |=> pgm_q);

  assert_key_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr >= ADDR_W'('h10) && bus_addr <= ADDR_W'('h2C)) |-> (bus_rdata == '0));

  assert_zeroize_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == ADDR_W'('h04) && bus_wdata[0]) |=> zeroized_q);

  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  assert_lock_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == ADDR_W'('h4C) && cfg_zero_pad) |-> (bus_rdata == '0));

  assert_busy_not_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    crc_busy |-> !crc_done);

  assert_mask_drops_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == ADDR_W'('h44) && bus_wdata[0]) |=> !irq);

  assert_partial_reads_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_word) |-> (bus_rdata == '0));
endmodule

bind keyvault_regctl kv_regctl_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_zero_pad(cfg_zero_pad),
  .bus_sel(bus_sel), .bus_we(bus_we), .bus_word(bus_word),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq(irq), .pgm_q(pgm_q), .lock_q(lock_q), .zeroized_q(zeroized_q),
  .crc_busy(crc_busy), .crc_done(crc_done)
);

// File: tb/keyvault_regctl_tb.sv
module keyvault_regctl_tb;
  logic clk, rst_n, cfg_zero_pad, bus_sel, bus_we, bus_word, err_event;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, rv;
  logic slverr_en, irq;
  int checks, errors;
  bit finished;
  logic [31:0] mk [8];

  keyvault_regctl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_zero_pad(cfg_zero_pad),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .err_event(err_event), .slverr_en(slverr_en), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input bit full = 1'b1);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_word = full; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_word = 1'b1;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d, input bit full = 1'b1);
    bus_sel = 1'b1; bus_we = 1'b0; bus_word = full; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0; bus_word = 1'b1;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    tick(2); rst_n = 1'b1;
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] k [8], input bit pad);
    logic [31:0] c;
    logic [7:0]  by;
    c = 32'hFFFFFFFF;
    for (int w = (pad ? -1 : 0); w < 8; w++) begin
      for (int b = 0; b < 4; b++) begin
        by = (w < 0) ? 8'h00 : k[w][8*b +: 8];
        c = c ^ {24'b0, by};
        for (int t = 0; t < 8; t++) c = c[0] ? ((c >> 1) ^ 32'h82F63B78) : (c >> 1);
      end
    end
    return ~c;
  endfunction

  // Start a walk and sample status on the edge before and at completion.
  task automatic crc_run(input string req, input logic [31:0] val, input int lat,
                         input bit exp_pass);
    wr(7'h0C, val);
    tick(lat - 1);
    rd(7'h00, rv); chk({req, " done still low"}, {30'b0, rv[9:8]}, 32'd0);
    tick(1);
    rd(7'h00, rv); chk({req, " done/pass"}, {30'b0, rv[9:8]}, {30'b0, exp_pass, 1'b1});
  endtask

  task automatic clear_model();
    for (int i = 0; i < 8; i++) mk[i] = '0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; finished = 0;
    rst_n = 1'b0; cfg_zero_pad = 1'b0; err_event = 1'b0;
    bus_sel = 1'b0; bus_we = 1'b0; bus_word = 1'b1; bus_addr = '0; bus_wdata = '0;
    clear_model();
    tick(3); rst_n = 1'b1; tick(1);

    // R1 reset state
    rd(7'h00, rv); chk("R1 status", rv, 32'h0);
    rd(7'h38, rv); chk("R1 isr", rv, 32'h0);
    rd(7'h3C, rv); chk("R1 imr", rv, 32'h1);
    rd(7'h4C, rv); chk("R1 lock", rv, 32'h0);
    rd(7'h34, rv); chk("R1 erren", rv, 32'h0);
    chk("R1 irq/slverr_en", {30'b0, irq, slverr_en}, 32'h0);

    // R12 partial accesses: sweep all word addresses, and a partial unlock
    for (int a = 0; a < 128; a += 4) begin
      rd(7'(a), rv, 1'b0); chk("R12 partial read", rv, 32'h0);
    end
    wr(7'h08, 32'h757BDF0D, 1'b0);
    rd(7'h00, rv); chk("R12 partial unlock ignored", rv, 32'h0);

    // R2 wrong unlock value, then right one
    wr(7'h08, 32'h757BDF0C);
    rd(7'h00, rv); chk("R2 wrong key ignored", rv, 32'h0);
    wr(7'h08, 32'h757BDF0D);
    rd(7'h00, rv); chk("R2 unlock status", rv, 32'h11);

    // R6 extra word writable and readable (cfg_zero_pad=0); R5 not counted
    wr(7'h30, 32'hA5A50001);
    rd(7'h30, rv); chk("R6 extra readback", rv, 32'hA5A50001);
    rd(7'h00, rv); chk("R5 extra write keeps wiped", rv, 32'h11);
    wr(7'h10, 32'h0);
    rd(7'h00, rv); chk("R5 zero key keeps wiped", rv, 32'h11);
    wr(7'h10, 32'h00001234); mk[0] = 32'h00001234;
    rd(7'h00, rv); chk("R5 nonzero key clears wiped", rv, 32'h01);

    // R3 read-zero sweep
    for (int a = 'h10; a <= 'h2C; a += 4) begin
      rd(7'(a), rv); chk("R3 key reads zero", rv, 32'h0);
    end
    foreach (mk[i]) begin end
    wr(7'h0C, 32'hFFFF_FFFF);
    rd(7'h0C, rv); chk("R3 checksum reads zero", rv, 32'h0);
    for (int a = 4; a <= 'h44; a += 'h3C) begin
      rd(7'(a), rv); chk("R3 strobe regs read zero", rv, 32'h0);
    end
    tick(12);

    // R8 full key pattern, no prefix, latency 8; mismatch
    for (int i = 0; i < 8; i++) begin
      mk[i] = 32'h01010101 * (i + 1) + 32'h11;
      wr(7'(16 + 4 * i), mk[i]);
    end
    crc_run("R8 nopad match", ref_crc(mk, 1'b0), 8, 1'b1);
    crc_run("R8 nopad mismatch", ref_crc(mk, 1'b0) ^ 32'h1, 8, 1'b0);

    // R13 restart mid-walk
    wr(7'h0C, 32'hDEADBEEF);
    tick(2);
    crc_run("R13 restart", ref_crc(mk, 1'b0), 8, 1'b1);

    // R4 zeroize via command; sweep single-word patterns through the CRC (R8)
    wr(7'h04, 32'h1); clear_model();
    rd(7'h00, rv); chk("R4 wiped flag", rv[4], 1'b1);
    rd(7'h04, rv); chk("R4 command self-clears", rv, 32'h0);
    rd(7'h30, rv); chk("R4 extra kept when readable", rv, 32'hA5A50001);
    crc_run("R4 zero keys", ref_crc(mk, 1'b0), 8, 1'b1);
    for (int i = 0; i < 8; i++) begin
      wr(7'h04, 32'h1); clear_model();
      mk[i] = 32'h80000000 | (32'h5 << (3 * i));
      wr(7'(16 + 4 * i), mk[i]);
      crc_run("R8 single-slot sweep", ref_crc(mk, 1'b0), 8, 1'b1);
    end

    // R7 lock sticky; R6 locked extra word rejects writes
    wr(7'h4C, 32'h1);
    rd(7'h4C, rv); chk("R7 lock set", rv, 32'h1);
    wr(7'h4C, 32'h0);
    rd(7'h4C, rv); chk("R7 lock sticky", rv, 32'h1);
    wr(7'h30, 32'h0000DEAD);
    rd(7'h30, rv); chk("R6 locked write ignored", rv, 32'hA5A50001);

    // R11 reset keeps storage; R6 and R9 outside program mode
    do_reset();
    rd(7'h00, rv); chk("R11 status cleared", rv, 32'h0);
    rd(7'h4C, rv); chk("R11 lock cleared", rv, 32'h0);
    rd(7'h30, rv); chk("R11 extra retained", rv, 32'hA5A50001);
    wr(7'h30, 32'h12345678);
    rd(7'h30, rv); chk("R6 write outside program mode", rv, 32'hA5A50001);
    wr(7'h0C, ref_crc(mk, 1'b0));
    tick(12);
    rd(7'h00, rv); chk("R9 checksum ignored", rv, 32'h0);

    // Prefix mode
    cfg_zero_pad = 1'b1;
    do_reset();
    rd(7'h30, rv); chk("R6 write-only reads zero", rv, 32'h0);
    wr(7'h4C, 32'h1);
    rd(7'h4C, rv); chk("R7 lock refused", rv, 32'h0);
    wr(7'h08, 32'h757BDF0D); clear_model();
    rd(7'h00, rv); chk("R2 unlock prefix mode", rv, 32'h11);
    wr(7'h30, 32'h00000077);
    rd(7'h00, rv); chk("R5 extra write clears wiped", rv, 32'h01);
    for (int i = 0; i < 8; i++) begin
      mk[i] = 32'hC3000000 + 32'h00010203 * i;
      wr(7'(16 + 4 * i), mk[i]);
    end
    crc_run("R8 pad match", ref_crc(mk, 1'b1), 9, 1'b1);
    crc_run("R8 prefix matters", ref_crc(mk, 1'b0), 9, 1'b0);
    wr(7'h04, 32'h1);
    cfg_zero_pad = 1'b0;
    rd(7'h30, rv); chk("R4 write-only extra wiped", rv, 32'h0);

    // R10 interrupt path
    @(negedge clk); err_event = 1'b1; @(negedge clk); err_event = 1'b0;
    rd(7'h38, rv); chk("R10 isr set", rv, 32'h1);
    chk("R10 masked irq", {31'b0, irq}, 32'h0);
    wr(7'h40, 32'h1);
    rd(7'h3C, rv); chk("R10 unmask", rv, 32'h0);
    chk("R10 irq raised", {31'b0, irq}, 32'h1);
    wr(7'h38, 32'h1);
    chk("R10 w1c drops irq", {31'b0, irq}, 32'h0);
    @(negedge clk); err_event = 1'b1; @(negedge clk); err_event = 1'b0;
    chk("R10 irq again", {31'b0, irq}, 32'h1);
    wr(7'h44, 32'h1);
    chk("R10 mask drops irq", {31'b0, irq}, 32'h0);

    // R14 enable register
    wr(7'h34, 32'h1);
    rd(7'h34, rv); chk("R14 erren readback", rv, 32'h1);
    chk("R14 slverr_en", {31'b0, slverr_en}, 32'h1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule